// File: doc/BRIEF.md
# Two-Wire Slave EEPROM Front End with Page Buffer

This block is the serial side of a small non-volatile store of 128 bytes. It sits on a two-wire (I2C) bus as a slave at the fixed 7-bit address `1010000`. It receives over-sampled SCL and SDA levels from pads that the system clock synchronises. It pulls SDA low through an output enable. It reaches the array through a plain memory port: a registered address, a write strobe and write data, and read data that must reflect `mem_addr` in the same cycle.

A write transfer has a control byte, then one word-address byte that loads the internal pointer, then any number of data bytes. The data bytes collect in an eight-entry page buffer. A stop condition commits the buffer in a self-timed write cycle of `WR_CYCLES` system clocks. While that cycle runs, the block acknowledges nothing, so a master can poll for completion. A read returns the byte at the pointer and advances the pointer. The master continues the read with ACK and ends it with NACK. The external protection logic supplies a single write-permit level that gates each transfer.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The block acknowledges a control byte only when its upper seven bits equal `1010000`. Bit 0 selects the direction (1 = read). Any other control byte gets no acknowledge, and the block stays silent until the next start.
- R2: In a write, the first byte after the control byte sets the pointer. Each later byte is acknowledged and buffered. A stop then writes the buffered bytes into the array at the pointer address.
- R3: After each buffered data byte only pointer bits [2:0] increment and bits [6:3] hold. More than eight bytes wrap within the page, and the later bytes replace the earlier ones.
- R4: A commit writes only those buffer slots that received a byte in this transfer. The other addresses of the page keep their contents.
- R5: From the stop that starts a commit until `WR_CYCLES` clocks later, the block acknowledges no byte, including its own control byte. After that it acknowledges again.
- R6: If `wr_permit` is low in any cycle between the write control byte and the stop, the array is not changed and no write cycle starts. The block still acknowledges the bytes of that transfer.
- R7: A repeated start after the word address ends the write without a commit, but the pointer keeps the new address (random read).
- R8: A read sends the byte at the pointer, MSB first, and the pointer increments after each byte. A master ACK continues with the next address. A master NACK ends the read, and SDA stays released until the next start. A read with no word address begins at the retained pointer.
- R9: The pointer wraps from address 7Fh to 00h during reads.
- R10: After reset, `sda_oe` and `mem_we` are low.
- R11: `sda_oe` rises only in the cycle after the synchronised SCL has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| wr_permit | input | 1 | High allows the current write transfer to program |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| mem_addr | output | AW | Array address (pointer, or commit address during a write cycle) |
| mem_rdata | input | 8 | Array data at `mem_addr`, same cycle |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |

## Verification
Bus edges pass through a two-flop synchroniser and an edge register, so `sda_oe` responds three to four clocks after an SCL edge. The bench keeps each SCL quarter period at ten clocks and samples SDA in the middle of the high phase, well after any such change. A commit starts in the cycle after the stop is detected and lasts `WR_CYCLES` clocks. The bench polls at once to see a NACK, then waits `WR_CYCLES` plus a margin before it expects an ACK and reads the array back.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int AW = 7,
  parameter int PW = 3,
  parameter int WR_CYCLES = 64,
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          wr_permit,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [7:0]    mem_wdata
);
  localparam int PAGE = 1 << PW;
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LAST_C = CW'(WR_CYCLES - 1);
  localparam logic [CW-1:0] PAGE_C = CW'(PAGE);

  typedef enum logic [2:0] {IDLE, CTRL, WADR, WDAT, RDAT} st_t;

  logic [2:0]      scl_q, sda_q;
  st_t             st;
  logic [3:0]      bitcnt;
  logic [7:0]      sh, tx;
  logic [AW-1:0]   ptr;
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] vld;
  logic            wr_ok, mack_n, busy;
  logic [CW-1:0]   wcnt;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop_c   = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
  wire buf_we   = (st == WDAT) && scl_fall && (bitcnt == 4'd8);
  wire [PW-1:0] cslot = wcnt[PW-1:0];

  assign mem_addr  = busy ? {ptr[AW-1:PW], cslot} : ptr;
  assign mem_we    = busy && (wcnt < PAGE_C) && vld[cslot];
  assign mem_wdata = pbuf[cslot];

  always_ff @(posedge clk)
    if (buf_we) pbuf[ptr[PW-1:0]] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1; sda_q <= '1;
      st <= IDLE; bitcnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      vld <= '0; wr_ok <= 1'b0; mack_n <= 1'b1; busy <= 1'b0;
      wcnt <= '0; sda_oe <= 1'b0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};

      if (busy) begin
        if (wcnt == LAST_C) busy <= 1'b0;
        else wcnt <= wcnt + 1'b1;
      end

      if (st == WADR || st == WDAT) wr_ok <= wr_ok & wr_permit;

      if (start_c) begin
        st <= CTRL; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        if (st == WDAT && |vld && wr_ok && wr_permit) begin
          busy <= 1'b1; wcnt <= '0;
        end
        st <= IDLE; sda_oe <= 1'b0;
      end else if (st != IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) sh <= {sh[6:0], sda_q[1]};
          if (bitcnt == 4'd8 && st == RDAT) mack_n <= sda_q[1];
          if (bitcnt != 4'd9) bitcnt <= bitcnt + 1'b1;
        end
        if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (st)
              CTRL:
                if (sh[7:1] == DEV_ID && !busy) begin
                  sda_oe <= 1'b1;
                  if (sh[0]) begin
                    st <= RDAT; mack_n <= 1'b0;
                  end else begin
                    st <= WADR; vld <= '0; wr_ok <= wr_permit;
                  end
                end else st <= IDLE;
              WADR: begin
                sda_oe <= 1'b1; ptr <= sh[AW-1:0]; st <= WDAT;
              end
              WDAT: begin
                sda_oe <= 1'b1;
                vld[ptr[PW-1:0]] <= 1'b1;
                ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
              end
              RDAT: begin
                sda_oe <= 1'b0; ptr <= ptr + 1'b1;
              end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            if (st == RDAT) begin
              if (mack_n) begin
                st <= IDLE; sda_oe <= 1'b0;
              end else begin
                tx <= mem_rdata; sda_oe <= ~mem_rdata[7];
              end
            end else sda_oe <= 1'b0;
          end else if (st == RDAT && bitcnt != 4'd0) begin
            tx <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk #(
  parameter int AW = 7,
  parameter int PW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic              busy,
  input logic              scl_fall,
  input logic [(1<<PW)-1:0] vld
);
  // R5
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  // R5
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R11
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R4
  commit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> vld[mem_addr[PW-1:0]]);
  // R3
  commit_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW]));
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .mem_we(mem_we),
  .mem_addr(mem_addr), .busy(busy), .scl_fall(scl_fall), .vld(vld)
);

// File: tb/eeprom_i2c_slave_test.sv
module eeprom_i2c_slave_test;
  localparam int WRC = 500;
  localparam int Q = 10;

  logic clk = 0, rst_n = 0;
  logic scl = 1, master_sda = 1, wr_permit = 1;
  logic sda_oe, mem_we;
  logic [6:0] mem_addr;
  logic [7:0] mem_rdata, mem_wdata;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  int tests = 0, fails = 0;
  bit done = 0;

  wire sda_line = master_sda & ~sda_oe;

  always #5 clk = ~clk;

  eeprom_i2c_slave #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .wr_permit(wr_permit), .sda_oe(sda_oe), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  assign mem_rdata = mem[mem_addr];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic start_c();
    master_sda = 1; wq(); scl = 1; wq(); master_sda = 0; wq(); scl = 0; wq();
  endtask

  task automatic stop_c();
    master_sda = 0; wq(); scl = 1; wq(); master_sda = 1; wq(); wq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    master_sda = b; wq(); scl = 1; wq(); s = sda_line; wq(); scl = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack_n);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(nack, s);
  endtask

  task automatic wait_commit(); repeat (WRC + 60) @(negedge clk); endtask

  task automatic write_page(input logic [6:0] addr, input int cnt, input logic [7:0] seed);
    logic a_n;
    logic [6:0] a;
    start_c();
    send_byte(8'hA0, a_n); chk("R1 write control ack", a_n, 0);
    send_byte({1'b0, addr}, a_n); chk("R2 word address ack", a_n, 0);
    a = addr;
    for (int i = 0; i < cnt; i++) begin
      send_byte(seed + 8'(i * 7), a_n);
      if (i == 0) chk("R2 data ack", a_n, 0);
      exp_mem[{addr[6:3], a[2:0]}] = seed + 8'(i * 7);
      a[2:0] = a[2:0] + 3'd1;
    end
    stop_c();
    wait_commit();
  endtask

  task automatic read_check(input logic [6:0] addr, input int cnt, input string tag);
    logic a_n;
    logic [7:0] d;
    start_c();
    send_byte(8'hA0, a_n);
    send_byte({1'b0, addr}, a_n);
    start_c();
    send_byte(8'hA1, a_n); chk("R7 read control ack after restart", a_n, 0);
    for (int i = 0; i < cnt; i++) begin
      recv_byte(i == cnt - 1, d);
      chk(tag, d, exp_mem[7'(addr + 7'(i))]);
    end
    stop_c();
  endtask

  task automatic t_reset();
    chk("R10 sda_oe at reset", 8'(sda_oe), 0);
    chk("R10 mem_we at reset", 8'(mem_we), 0);
  endtask

  task automatic t_mismatch();
    logic a_n;
    start_c();
    send_byte(8'hA4, a_n); chk("R1 foreign address no ack", a_n, 1);
    send_byte(8'h00, a_n); chk("R1 silent after mismatch", a_n, 1);
    stop_c();
  endtask

  task automatic t_byte_write_poll();
    logic a_n;
    start_c();
    send_byte(8'hA0, a_n);
    send_byte(8'h10, a_n);
    send_byte(8'h3C, a_n); chk("R2 byte write data ack", a_n, 0);
    stop_c();
    exp_mem[8'h10] = 8'h3C;
    start_c();
    send_byte(8'hA0, a_n); chk("R5 no ack while writing", a_n, 1);
    stop_c();
    wait_commit();
    start_c();
    send_byte(8'hA0, a_n); chk("R5 ack after write cycle", a_n, 0);
    stop_c();
    read_check(7'h10, 2, "R2 byte write readback");
  endtask

  task automatic t_page_wrap();
    write_page(7'h1D, 10, 8'h40);
    read_check(7'h18, 8, "R3 page wrap contents");
    chk("R3 next page untouched", mem[8'h20], exp_mem[8'h20]);
  endtask

  task automatic t_partial();
    write_page(7'h22, 2, 8'h90);
    read_check(7'h20, 8, "R4 partial page");
  endtask

  task automatic t_permit();
    logic a_n;
    start_c();
    send_byte(8'hA0, a_n);
    send_byte(8'h40, a_n);
    wr_permit = 0;
    send_byte(8'h77, a_n); chk("R6 ack while blocked", a_n, 0);
    wr_permit = 1;
    send_byte(8'h78, a_n);
    stop_c();
    start_c();
    send_byte(8'hA0, a_n); chk("R6 no write cycle started", a_n, 0);
    stop_c();
    read_check(7'h40, 2, "R6 array unchanged");
  endtask

  task automatic t_wrap_current();
    logic a_n;
    logic [7:0] d;
    read_check(7'h7E, 3, "R9 pointer wrap 7F to 00");
    start_c();
    send_byte(8'hA1, a_n); chk("R8 current read ack", a_n, 0);
    recv_byte(1'b1, d); chk("R8 current address read", d, exp_mem[1]);
    wq();
    chk("R8 released after nack", 8'(sda_oe), 0);
    stop_c();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_mismatch();
    t_byte_write_poll();
    t_page_wrap();
    t_partial();
    t_permit();
    t_wrap_current();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule